// File: doc/BRIEF.md
# Storage Exception Priority and Syndrome Logic

This block decides which storage fault an instruction reports when its memory access has failed, and it fills in the syndrome word that the interrupt handler reads. Several data-side fault conditions can be flagged for the same instruction. The block sorts them by a fixed priority and reports only the winner. It raises a one-cycle interrupt request and loads a cause code and a syndrome register. The syndrome holds the winner's cause bits and two qualifier bits that describe the instruction class.

A fault seen while an instruction was being fetched does not interrupt at once. The block keeps it as a tag that travels with the instruction through a short in-order queue of `DEPTH` slots. The tag takes effect only when that instruction attempts to execute. A flush empties the queue, and any tag in it is lost. An external pending higher-priority exception blocks every request from this block.

Top module: `se_storage_exc`

## Requirements
- R1: When data faults are active together, `cause_o` reports the highest one in this order, from highest to lowest: lock (1), page-table fault (2), virtualization (3), TLB-ineligible (4), byte order (5), read/write access (6), unavailable coprocessor (7). `irq_o` high never comes with cause 0.
- R2: At most one cause bit is set in `syn_o`, and every bit that the reported cause and class do not name is 0. The cause bits are lock field [1:0], PT [2], TLBI [3], BO [4] and UCT [5].
- R3: For a lock cause, `syn_o[1:0]` equals the `lock_i` value. Any nonzero `lock_i` counts as a lock fault.
- R4: A page-table-fault cause sets PT. A read/write cause sets PT only when `walk_i` is high and `tlb_made_i` is low. Otherwise PT is 0.
- R5: A TLB-ineligible cause sets TLBI only when `walk_i` is high.
- R6: A byte-order cause sets BO, and an unavailable-coprocessor cause sets UCT.
- R7: For a data cause, `syn_o[6]` copies `axu_i` and `syn_o[7]` copies `epid_i`.
- R8: A fetch-time fault (`fetch_isx_i`) raises the request only when its instruction attempts execute. That attempt is the `DEPTH`-th advance after it was accepted. The cause is then 8 and the syndrome is all zero, and this cause beats any data flags of that cycle.
- R9: After a flush, no fetch-time fault accepted before or with it is ever reported, and no request follows the flush cycle.
- R10: While `ext_block_i` is high, no request is raised, and the cause and syndrome keep their values.
- R11: `irq_o` pulses in the cycle after an execute attempt that has a fault. The cause and syndrome change only at that edge and otherwise hold.
- R12: Reset clears `irq_o`, `cause_o`, `syn_o` and the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance: the head instruction attempts execute, the queue shifts and the fetch input enters |
| flush_i | input | 1 | Empties the queue and cancels this cycle's attempt |
| fetch_v_i | input | 1 | A valid instruction enters on advance |
| fetch_isx_i | input | 1 | The entering instruction had a fetch-time fault |
| ext_block_i | input | 1 | A higher-priority exception is pending elsewhere |
| lock_i | input | 2 | Cache-lock fault kind; 0 means none |
| ptf_i | input | 1 | Page-table fault |
| virt_i | input | 1 | Virtualization fault |
| tlbi_i | input | 1 | TLB-ineligible fault |
| bo_i | input | 1 | Byte-order fault |
| rw_i | input | 1 | Read/write access fault |
| uct_i | input | 1 | Unavailable coprocessor type |
| walk_i | input | 1 | The access ran a page-table translation |
| tlb_made_i | input | 1 | The walk created a TLB entry |
| axu_i | input | 1 | The instruction is an auxiliary-unit load or store |
| epid_i | input | 1 | The instruction is an external process ID access |
| irq_o | output | 1 | Storage interrupt request pulse |
| cause_o | output | 4 | Reported cause code |
| syn_o | output | 8 | Syndrome value |

## Verification
All three outputs are registered, so the request, cause and syndrome for an execute attempt are due one clock edge after the cycle in which `adv_i` was high. A fetch-time fault is due one edge after the `DEPTH`-th advance that follows its acceptance. The bench drives inputs at the falling edge and moves its own queue model in step with each advance. It compares every output at the next falling edge, so each expectation is matched to the single edge that produces it.

// File: rtl/se_pkg.sv
package se_pkg;

  localparam int unsigned SYN_W   = 8;
  localparam int unsigned CAUSE_W = 4;
  localparam int unsigned LK_LO   = 0;
  localparam int unsigned PT_B    = 2;
  localparam int unsigned TI_B    = 3;
  localparam int unsigned BO_B    = 4;
  localparam int unsigned UC_B    = 5;
  localparam int unsigned AX_B    = 6;
  localparam int unsigned EP_B    = 7;

  typedef enum logic [CAUSE_W-1:0] {
    C_NONE = 4'd0,
    C_LOCK = 4'd1,
    C_PTF  = 4'd2,
    C_VIRT = 4'd3,
    C_TLBI = 4'd4,
    C_BO   = 4'd5,
    C_RW   = 4'd6,
    C_UCT  = 4'd7,
    C_ISI  = 4'd8
  } cause_e;

  typedef struct packed {
    logic [1:0] lock;
    logic       ptf;
    logic       virt;
    logic       tlbi;
    logic       bo;
    logic       rw;
    logic       uct;
  } dflags_t;

  typedef struct packed {
    logic walk;
    logic tlb_made;
    logic axu;
    logic epid;
  } ctx_t;

  function automatic logic any_fault(input logic isx, input dflags_t f);
    return isx | (|f.lock) | f.ptf | f.virt | f.tlbi | f.bo | f.rw | f.uct;
  endfunction

  // Fixed priority: fetch-time tag first (its data access never happened),
  // then data faults from lock down to unavailable coprocessor.
  function automatic cause_e pick_cause(input logic isx, input dflags_t f);
    cause_e c;
    if (isx)           c = C_ISI;
    else if (|f.lock)  c = C_LOCK;
    else if (f.ptf)    c = C_PTF;
    else if (f.virt)   c = C_VIRT;
    else if (f.tlbi)   c = C_TLBI;
    else if (f.bo)     c = C_BO;
    else if (f.rw)     c = C_RW;
    else if (f.uct)    c = C_UCT;
    else               c = C_NONE;
    return c;
  endfunction

  function automatic logic [SYN_W-1:0] build_syn(input cause_e c, input dflags_t f,
                                                 input ctx_t x);
    logic [SYN_W-1:0] s;
    s = '0;
    if (c != C_NONE && c != C_ISI) begin
      s[AX_B] = x.axu;
      s[EP_B] = x.epid;
    end
    case (c)
      C_LOCK:  s[LK_LO +: 2] = f.lock;
      C_PTF:   s[PT_B] = 1'b1;
      C_RW:    s[PT_B] = x.walk & ~x.tlb_made;
      C_TLBI:  s[TI_B] = x.walk;
      C_BO:    s[BO_B] = 1'b1;
      C_UCT:   s[UC_B] = 1'b1;
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/se_tag_pipe.sv
module se_tag_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic flush,
  input  logic in_v,
  input  logic in_isx,
  output logic head_v,
  output logic head_isx
);

  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] x_q;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic nv, nx;
    if (gi == 0) begin : g_first
      assign nv = in_v;
      assign nx = in_v & in_isx;
    end else begin : g_rest
      assign nv = v_q[gi-1];
      assign nx = x_q[gi-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[gi] <= 1'b0;
        x_q[gi] <= 1'b0;
      end else if (flush) begin
        v_q[gi] <= 1'b0;
        x_q[gi] <= 1'b0;
      end else if (adv) begin
        v_q[gi] <= nv;
        x_q[gi] <= nx;
      end
    end
  end

  assign head_v   = v_q[DEPTH-1];
  assign head_isx = x_q[DEPTH-1];

endmodule

// File: rtl/se_prio.sv
module se_prio
  import se_pkg::*;
(
  input  logic             exec_try,
  input  logic             head_isx,
  input  logic             block,
  input  dflags_t          flags,
  input  ctx_t             ctx,
  output logic             req,
  output cause_e           cause,
  output logic [SYN_W-1:0] syn_next
);

  always_comb begin
    cause    = pick_cause(head_isx, flags);
    req      = exec_try & ~block & any_fault(head_isx, flags);
    syn_next = build_syn(cause, flags, ctx);
  end

endmodule

// File: rtl/se_syn_reg.sv
module se_syn_reg
  import se_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  cause_e             cause_in,
  input  logic [SYN_W-1:0]   syn_in,
  output logic               irq,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [SYN_W-1:0]   syn_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      cause_q <= '0;
      syn_q   <= '0;
    end else begin
      irq <= load;
      if (load) begin
        cause_q <= cause_in;
        syn_q   <= syn_in;
      end
    end
  end

endmodule

// File: rtl/se_storage_exc.sv
module se_storage_exc
  import se_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  input  logic               flush_i,
  input  logic               fetch_v_i,
  input  logic               fetch_isx_i,
  input  logic               ext_block_i,
  input  logic [1:0]         lock_i,
  input  logic               ptf_i,
  input  logic               virt_i,
  input  logic               tlbi_i,
  input  logic               bo_i,
  input  logic               rw_i,
  input  logic               uct_i,
  input  logic               walk_i,
  input  logic               tlb_made_i,
  input  logic               axu_i,
  input  logic               epid_i,
  output logic               irq_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [SYN_W-1:0]   syn_o
);

  logic             head_v;
  logic             head_isx;
  logic             exec_try;
  logic             req;
  cause_e           sel_cause;
  logic [SYN_W-1:0] syn_next;
  dflags_t          flags;
  ctx_t             ctx;

  assign flags = '{lock: lock_i, ptf: ptf_i, virt: virt_i, tlbi: tlbi_i,
                   bo: bo_i, rw: rw_i, uct: uct_i};
  assign ctx   = '{walk: walk_i, tlb_made: tlb_made_i, axu: axu_i, epid: epid_i};

  // An execute attempt needs an instruction at the head and no flush.
  assign exec_try = adv_i & ~flush_i & head_v;

  se_tag_pipe #(.DEPTH(DEPTH)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv_i),
    .flush    (flush_i),
    .in_v     (fetch_v_i),
    .in_isx   (fetch_isx_i),
    .head_v   (head_v),
    .head_isx (head_isx)
  );

  se_prio u_prio (
    .exec_try (exec_try),
    .head_isx (head_isx),
    .block    (ext_block_i),
    .flags    (flags),
    .ctx      (ctx),
    .req      (req),
    .cause    (sel_cause),
    .syn_next (syn_next)
  );

  se_syn_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (req),
    .cause_in (sel_cause),
    .syn_in   (syn_next),
    .irq      (irq_o),
    .cause_q  (cause_o),
    .syn_q    (syn_o)
  );

endmodule

// File: rtl/se_storage_exc_chk.sv
module se_storage_exc_chk
  import se_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic               ext_block_i,
  input logic               exec_try,
  input logic               head_isx,
  input logic               irq_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [SYN_W-1:0]   syn_o
);

  p_nonnull_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cause_o != C_NONE);

  p_single_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $countones({|syn_o[1:0], syn_o[PT_B], syn_o[TI_B], syn_o[BO_B], syn_o[UC_B]}) <= 1);

  p_isi_zero_syn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && cause_o == C_ISI) |-> syn_o == '0);

  p_isi_from_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && cause_o == C_ISI) |-> $past(exec_try && head_isx));

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !irq_o);

  p_block_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_block_i |=> !irq_o);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> ($stable(syn_o) && $stable(cause_o)));

  p_needs_attempt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_try |=> !irq_o);

endmodule

bind se_storage_exc se_storage_exc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush_i     (flush_i),
  .ext_block_i (ext_block_i),
  .exec_try    (exec_try),
  .head_isx    (head_isx),
  .irq_o       (irq_o),
  .cause_o     (cause_o),
  .syn_o       (syn_o)
);

// File: tb/test_se_storage_exc.sv
`timescale 1ns/1ps
module test_se_storage_exc;

  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv, flush, fv, fisx, blk, ptf, virt, tlbi, bo, rw, uct, walk, made, axu, epid;
  logic [1:0] lock;
  logic irq;
  logic [3:0] cause;
  logic [7:0] syn;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [DEPTH-1:0] m_v, m_x;
  logic       e_irq;
  logic [3:0] e_cause;
  logic [7:0] e_syn;

  always #10 clk = ~clk;

  se_storage_exc #(.DEPTH(DEPTH)) i_se_storage_exc (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .flush_i(flush), .fetch_v_i(fv),
    .fetch_isx_i(fisx), .ext_block_i(blk), .lock_i(lock), .ptf_i(ptf),
    .virt_i(virt), .tlbi_i(tlbi), .bo_i(bo), .rw_i(rw), .uct_i(uct),
    .walk_i(walk), .tlb_made_i(made), .axu_i(axu), .epid_i(epid),
    .irq_o(irq), .cause_o(cause), .syn_o(syn)
  );

  function automatic logic [3:0] m_cause(logic isx);
    logic [6:0] pr;
    pr = {|lock, ptf, virt, tlbi, bo, rw, uct};
    if (isx) return 4'd8;
    for (int k = 6; k >= 0; k--) if (pr[k]) return 4'(7 - k);
    return 4'd0;
  endfunction

  function automatic logic [7:0] m_syn(logic [3:0] c);
    logic [7:0] s;
    s = 8'h00;
    if (c != 4'd0 && c != 4'd8) s[7:6] = {epid, axu};
    case (c)
      4'd1: s[1:0] = lock;
      4'd2: s[2] = 1'b1;
      4'd6: s[2] = walk && !made;
      4'd4: s[3] = walk;
      4'd5: s[4] = 1'b1;
      4'd7: s[5] = 1'b1;
      default: ;
    endcase
    return s;
  endfunction

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R1";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R4";
      4'd7: return "R6";
      4'd8: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [7:0] got, logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    adv = 0; flush = 0; fv = 0; fisx = 0; blk = 0; lock = 0;
    ptf = 0; virt = 0; tlbi = 0; bo = 0; rw = 0; uct = 0;
    walk = 0; made = 0; axu = 0; epid = 0;
  endtask

  task automatic clr_flags();
    lock = 0; ptf = 0; virt = 0; tlbi = 0; bo = 0; rw = 0; uct = 0;
    walk = 0; made = 0; axu = 0; epid = 0; blk = 0; flush = 0;
  endtask

  // Called at a falling edge with inputs set; checks one edge later.
  task automatic step(string tag);
    logic try_e, fault, req;
    logic [3:0] c;
    string t;
    try_e = adv && !flush && m_v[DEPTH-1];
    c = m_cause(m_x[DEPTH-1]);
    fault = (c != 4'd0);
    req = try_e && !blk && fault;
    if (flush) begin
      m_v = '0; m_x = '0;
    end else if (adv) begin
      m_v = {m_v[DEPTH-2:0], fv};
      m_x = {m_x[DEPTH-2:0], fv && fisx};
    end
    e_irq = req;
    if (req) begin
      e_cause = c;
      e_syn = m_syn(c);
    end
    t = (tag != "") ? tag : (blk ? "R10" : (flush ? "R9" : tag_of(req ? c : 4'd0)));
    @(posedge clk);
    @(negedge clk);
    check(t, "irq", {7'd0, irq}, {7'd0, e_irq});
    check(t, "cause", {4'd0, cause}, {4'd0, e_cause});
    check(t, "syn", syn, e_syn);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    idle();
    m_v = '0; m_x = '0;
    e_irq = 0; e_cause = 0; e_syn = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "irq", {7'd0, irq}, 8'd0);
    check("R12", "cause", {4'd0, cause}, 8'd0);
    check("R12", "syn", syn, 8'd0);
    rst_n = 1;
    @(negedge clk);
    // R12: empty queue, advance with fault flags must not interrupt
    adv = 1; ptf = 1;
    step("R12");
    clr_flags();
    fv = 1;
    for (int i = 0; i < DEPTH; i++) step("R11");

    // R1 R3: all faults together, lock wins
    lock = 2'b01; ptf = 1; virt = 1; tlbi = 1; bo = 1; rw = 1; uct = 1; walk = 1; axu = 1;
    step("R1");
    clr_flags(); lock = 2'b10; step("R3");
    // R2 R4: ptf over tlbi and bo
    clr_flags(); ptf = 1; tlbi = 1; bo = 1; walk = 1; step("R2");
    // R1: virtualization over rw and uct, no cause bit
    clr_flags(); virt = 1; rw = 1; uct = 1; walk = 1; step("R1");
    // R4: rw with and without walk / entry
    clr_flags(); rw = 1; walk = 1; made = 0; step("R4");
    clr_flags(); rw = 1; walk = 1; made = 1; step("R4");
    clr_flags(); rw = 1; walk = 0; step("R4");
    // R5: tlbi with and without walk
    clr_flags(); tlbi = 1; walk = 0; step("R5");
    clr_flags(); tlbi = 1; walk = 1; step("R5");
    // R6: bo over uct, then uct alone
    clr_flags(); bo = 1; uct = 1; step("R6");
    clr_flags(); uct = 1; step("R6");
    // R7: class qualifiers
    clr_flags(); bo = 1; epid = 1; step("R7");
    clr_flags(); rw = 1; axu = 1; epid = 1; step("R7");
    // R11: no fault, and fault without advance
    clr_flags(); step("R11");
    adv = 0; ptf = 1; step("R11");
    adv = 1; clr_flags();

    // R8: fetch-time fault deferred to execute, beats data flags
    fisx = 1; step("R8");
    fisx = 0;
    for (int i = 0; i < DEPTH - 1; i++) step("R8");
    ptf = 1; lock = 2'b11; step("R8");
    clr_flags(); step("R8");

    // R9: flushed tag never reported
    fisx = 1; step("R9");
    fisx = 0; step("R9");
    flush = 1; ptf = 1; step("R9");
    clr_flags();
    for (int i = 0; i < DEPTH; i++) step("R9");

    // R10: external block suppresses and keeps syndrome
    uct = 1; blk = 1; step("R10");
    clr_flags(); fisx = 1; step("R10");
    fisx = 0;
    for (int i = 0; i < DEPTH - 1; i++) step("R10");
    blk = 1; step("R10");
    blk = 0; bo = 1; step("R6");
    clr_flags();

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      adv  = ($urandom % 4) != 0;
      flush = ($urandom % 16) == 0;
      blk  = ($urandom % 16) == 0;
      fv   = ($urandom % 8) != 0;
      fisx = ($urandom % 8) == 0;
      lock = (($urandom % 6) == 0) ? 2'(($urandom % 3) + 1) : 2'b00;
      ptf  = ($urandom % 5) == 0;
      virt = ($urandom % 5) == 0;
      tlbi = ($urandom % 5) == 0;
      bo   = ($urandom % 5) == 0;
      rw   = ($urandom % 5) == 0;
      uct  = ($urandom % 5) == 0;
      walk = ($urandom % 2) == 0;
      made = ($urandom % 2) == 0;
      axu  = ($urandom % 3) == 0;
      epid = ($urandom % 3) == 0;
      step("");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule